// File: doc/BRIEF.md
# Measurement Standby and Conversion Sequencer

This block decides when a temperature converter runs and when its results reach the result register. A stop bit in an 8-bit configuration byte selects the mode. With the stop bit clear, the block is in run mode: it enables the converter, the control loop and the fan driver, and it starts a conversion at a fixed interval of system clocks. With the stop bit set, the block is in standby: those three enables drop, the stored result is kept, and a conversion runs only when a one-shot request arrives. Each one-shot request runs exactly one conversion, after which the block returns to idle standby.

The converter sits outside this block and talks to it through a two-signal handshake. The block sends a one-cycle start pulse. The converter later returns a one-cycle done pulse together with its data word. If standby is requested while a run-mode conversion is still in flight, the block drops that conversion and raises a one-cycle abort pulse. Any result belonging to a dropped conversion never reaches the result register, so the previous value stays readable.

Top module: `conv_seq_ctrl`

## Requirements
- R1: While reset is held, and after it is released, `result_q` is zero. In the same period `conv_start`, `conv_abort`, `result_upd`, `adc_en`, `loop_en` and `fan_en` are all low, which means the block leaves reset in idle standby.
- R2: Standby is selected when bit 6 of `cfg_byte` is 1; the other bits of `cfg_byte` have no effect. One clock after the request is sampled, `adc_en`, `loop_en` and `fan_en` are low. In run mode all three are high.
- R3: In run mode `conv_start` is a one-cycle pulse that repeats every PERIOD clocks. The first pulse after leaving standby comes PERIOD+1 clocks after the clock on which `cfg_byte` bit 6 is cleared.
- R4: A one-shot request received in run mode is ignored: it produces no extra `conv_start` and does not shift the period.
- R5: In standby no periodic conversion starts. A one-shot request produces exactly one `conv_start`, one clock later. While that conversion runs, `adc_en` is high and `loop_en` and `fan_en` stay low.
- R6: After a one-shot conversion completes, the block returns to idle standby. `adc_en` is low again and no further `conv_start` occurs.
- R7: If standby is requested during a run-mode conversion, `conv_abort` pulses one clock later and `result_q` is not changed.
- R8: If a standby request and `conv_done` occur in the same cycle during a run-mode conversion, the standby request wins: `conv_abort` pulses and the data is discarded.
- R9: `result_q` takes `conv_data` one clock after a `conv_done` that belongs to a conversion that was not aborted, and `result_upd` pulses in the same cycle. A `conv_done` at any other time leaves `result_q` unchanged and `result_upd` low.
- R10: Entering and leaving standby leaves `result_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_byte | input | 8 | Configuration byte; bit 6 = 1 selects standby |
| oneshot_req | input | 1 | One-cycle one-shot conversion request |
| conv_done | input | 1 | One-cycle converter completion pulse |
| conv_data | input | DW | Converter result, valid with `conv_done` |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_abort | output | 1 | One-cycle pulse: in-flight conversion dropped |
| adc_en | output | 1 | Converter enable |
| loop_en | output | 1 | Control-loop enable |
| fan_en | output | 1 | Fan-driver enable |
| result_q | output | DW | Result register |
| result_upd | output | 1 | One-cycle pulse when `result_q` was written |

## Verification
The hardest case to reach from the ports is a standby request that lands in the same cycle as the converter's done pulse, in the middle of a run-mode conversion. The bench first waits until it sees a periodic `conv_start` at a falling edge, so it knows the conversion is in flight. On a later falling edge it drives `conv_done`, fresh data and the stop bit together. It then checks for the abort pulse and confirms that the old result is still held. A second scenario sends a late done pulse after an abort, to confirm that a stray completion writes nothing.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    typedef enum logic [1:0] {
        ST_STBY_IDLE = 2'd0,
        ST_STBY_CONV = 2'd1,
        ST_RUN_IDLE  = 2'd2,
        ST_RUN_CONV  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic adc;
        logic loop;
        logic fan;
    } en_vec_t;

    function automatic logic is_run(input seq_state_e s);
        return (s == ST_RUN_IDLE) || (s == ST_RUN_CONV);
    endfunction

    function automatic en_vec_t en_decode(input seq_state_e s);
        en_vec_t e;
        e.adc  = is_run(s) || (s == ST_STBY_CONV);
        e.loop = is_run(s);
        e.fan  = is_run(s);
        return e;
    endfunction

endpackage

// File: rtl/conv_tick_timer.sv
module conv_tick_timer #(
    parameter int PERIOD = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run_active,
    output logic tick
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    assign tick = run_active && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run_active) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3: ticks are spaced by PERIOD, never back to back
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/conv_mode_fsm.sv
module conv_mode_fsm
    import conv_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stby_req,
    input  logic       oneshot,
    input  logic       tick,
    input  logic       conv_done,
    output seq_state_e state,
    output logic       conv_start,
    output logic       conv_abort,
    output logic       commit,
    output logic       run_active
);
    seq_state_e nxt;
    logic       start_n;
    logic       abort_n;

    assign run_active = is_run(state);

    always_comb begin
        nxt     = state;
        start_n = 1'b0;
        abort_n = 1'b0;
        commit  = 1'b0;
        case (state)
            ST_STBY_IDLE: begin
                if (!stby_req) begin
                    nxt = ST_RUN_IDLE;
                end else if (oneshot) begin
                    nxt     = ST_STBY_CONV;
                    start_n = 1'b1;
                end
            end
            ST_STBY_CONV: begin
                if (conv_done) begin
                    commit = 1'b1;
                    nxt    = stby_req ? ST_STBY_IDLE : ST_RUN_IDLE;
                end else if (!stby_req) begin
                    nxt = ST_RUN_CONV;
                end
            end
            ST_RUN_IDLE: begin
                if (stby_req) begin
                    nxt = ST_STBY_IDLE;
                end else if (tick) begin
                    nxt     = ST_RUN_CONV;
                    start_n = 1'b1;
                end
            end
            ST_RUN_CONV: begin
                if (stby_req) begin
                    nxt     = ST_STBY_IDLE;
                    abort_n = 1'b1;
                end else if (conv_done) begin
                    commit = 1'b1;
                    nxt    = ST_RUN_IDLE;
                end
            end
            default: nxt = ST_STBY_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_STBY_IDLE;
            conv_start <= 1'b0;
            conv_abort <= 1'b0;
        end else begin
            state      <= nxt;
            conv_start <= start_n;
            conv_abort <= abort_n;
        end
    end

    // R2: a sampled standby request leaves run mode on the next clock
    p_stby_leaves_run_r2: assert property (@(posedge clk) disable iff (rst)
        stby_req |=> !run_active);

    // R4: outside a timer tick, run idle never launches a conversion
    p_run_oneshot_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN_IDLE && !tick) |=> !conv_start);

    // R5: start is a single-cycle pulse
    p_start_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    // R7: standby during a run conversion produces an abort
    p_abort_on_stby_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN_CONV && stby_req) |=> (conv_abort && state == ST_STBY_IDLE));

    // R8: standby beats a coincident done
    p_stby_beats_done_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN_CONV && stby_req && conv_done) |=> !is_run(state) && conv_abort);

endmodule

// File: rtl/conv_result_reg.sv
module conv_result_reg #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          commit,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] result_q,
    output logic          result_upd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            result_q   <= '0;
            result_upd <= 1'b0;
        end else begin
            result_upd <= commit;
            if (commit) begin
                result_q <= data_in;
            end
        end
    end

    // R9: without a commit the stored result is held
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(result_q));

    // R9: a commit is reported by the update pulse
    p_upd_follows_r9: assert property (@(posedge clk) disable iff (rst)
        commit |=> result_upd);

endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
    import conv_seq_pkg::*;
#(
    parameter int PERIOD   = 1000,
    parameter int DW       = 12,
    parameter int CFG_W    = 8,
    parameter int STBY_BIT = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_byte,
    input  logic             oneshot_req,
    input  logic             conv_done,
    input  logic [DW-1:0]    conv_data,
    output logic             conv_start,
    output logic             conv_abort,
    output logic             adc_en,
    output logic             loop_en,
    output logic             fan_en,
    output logic [DW-1:0]    result_q,
    output logic             result_upd
);
    localparam logic [CFG_W-1:0] STBY_MASK = CFG_W'(1) << STBY_BIT;

    logic       stby_req;
    logic       tick;
    logic       commit;
    logic       run_active;
    seq_state_e state;
    en_vec_t    en;

    assign stby_req = |(cfg_byte & STBY_MASK);

    conv_tick_timer #(.PERIOD(PERIOD)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .run_active (run_active),
        .tick       (tick)
    );

    conv_mode_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .stby_req   (stby_req),
        .oneshot    (oneshot_req),
        .tick       (tick),
        .conv_done  (conv_done),
        .state      (state),
        .conv_start (conv_start),
        .conv_abort (conv_abort),
        .commit     (commit),
        .run_active (run_active)
    );

    conv_result_reg #(.DW(DW)) u_result (
        .clk        (clk),
        .rst        (rst),
        .commit     (commit),
        .data_in    (conv_data),
        .result_q   (result_q),
        .result_upd (result_upd)
    );

    assign en      = en_decode(state);
    assign adc_en  = en.adc;
    assign loop_en = en.loop;
    assign fan_en  = en.fan;

    // R7: an abort never coincides with a result write
    p_abort_keeps_result_r7: assert property (@(posedge clk) disable iff (rst)
        conv_abort |-> (!result_upd && $stable(result_q)));

    // R2: standby keeps loop and fan drivers off
    p_stby_disable_r2: assert property (@(posedge clk) disable iff (rst)
        $past(stby_req) |-> (!loop_en && !fan_en));

endmodule

// File: tb/conv_seq_ctrl_tb_top.sv
module conv_seq_ctrl_tb_top;
    localparam int BP = 20;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic [7:0]    cfg_byte;
    logic          oneshot_req;
    logic          conv_done;
    logic [DW-1:0] conv_data;
    logic          conv_start;
    logic          conv_abort;
    logic          adc_en;
    logic          loop_en;
    logic          fan_en;
    logic [DW-1:0] result_q;
    logic          result_upd;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    conv_seq_ctrl #(.PERIOD(BP), .DW(DW)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .cfg_byte    (cfg_byte),
        .oneshot_req (oneshot_req),
        .conv_done   (conv_done),
        .conv_data   (conv_data),
        .conv_start  (conv_start),
        .conv_abort  (conv_abort),
        .adc_en      (adc_en),
        .loop_en     (loop_en),
        .fan_en      (fan_en),
        .result_q    (result_q),
        .result_upd  (result_upd)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_start(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!conv_start && cyc < 4*BP);
    endtask

    task automatic count_starts(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (conv_start) n++;
        end
    endtask

    // From a start cycle: complete the conversion, optionally poke one-shot, measure to next start
    task automatic measure_period(input logic [DW-1:0] d, input bit shoot, output int cyc);
        cyc = 0;
        repeat (2) begin @(negedge clk); cyc++; end
        conv_done = 1'b1; conv_data = d;
        @(negedge clk); cyc++;
        conv_done = 1'b0;
        chk("R9", "run result written", result_q, d);
        chk("R9", "run update pulse", result_upd, 1);
        if (shoot) begin
            oneshot_req = 1'b1;
            @(negedge clk); cyc++;
            oneshot_req = 1'b0;
        end
        while (!conv_start && cyc < 4*BP) begin
            @(negedge clk); cyc++;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; cfg_byte = 8'h40; oneshot_req = 1'b0; conv_done = 1'b0; conv_data = '0;
        repeat (3) @(negedge clk);
        chk("R1", "reset result", result_q, 0);
        chk("R1", "reset start", conv_start, 0);
        chk("R1", "reset abort", conv_abort, 0);
        chk("R1", "reset upd", result_upd, 0);
        chk("R1", "reset enables", {adc_en, loop_en, fan_en}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "post reset enables", {adc_en, loop_en, fan_en}, 0);
    endtask

    task automatic t_standby_quiet();
        int n;
        cfg_byte = 8'hC5;  // bit 6 set plus unrelated bits
        count_starts(2*BP, n);
        chk("R5", "no periodic starts in standby", n, 0);
        chk("R2", "standby enables low", {adc_en, loop_en, fan_en}, 0);
    endtask

    task automatic t_oneshot();
        int n;
        oneshot_req = 1'b1;
        @(negedge clk);
        oneshot_req = 1'b0;
        chk("R5", "one-shot start", conv_start, 1);
        chk("R5", "one-shot enables adc only", {adc_en, loop_en, fan_en}, 3'b100);
        @(negedge clk);
        chk("R5", "start is one cycle", conv_start, 0);
        conv_done = 1'b1; conv_data = 12'h3A5;
        @(negedge clk);
        conv_done = 1'b0;
        chk("R9", "one-shot result", result_q, 12'h3A5);
        chk("R9", "one-shot upd", result_upd, 1);
        chk("R6", "back to idle standby", {adc_en, loop_en, fan_en}, 0);
        count_starts(2*BP, n);
        chk("R6", "no starts after one-shot", n, 0);
    endtask

    task automatic t_run_period();
        int cyc;
        cfg_byte = 8'h3F;  // bit 6 clear, others set
        wait_start(cyc);
        chk("R3", "first start after leaving standby", cyc, BP+1);
        chk("R2", "run enables high", {adc_en, loop_en, fan_en}, 3'b111);
        chk("R10", "result kept over standby exit", result_q, 12'h3A5);
        measure_period(12'h111, 1'b0, cyc);
        chk("R3", "run period", cyc, BP);
        measure_period(12'h222, 1'b1, cyc);
        chk("R4", "one-shot ignored in run", cyc, BP);
    endtask

    task automatic t_abort();
        int cyc;
        // at a start cycle: conversion in flight
        cfg_byte = 8'h40;
        @(negedge clk);
        chk("R7", "abort pulse", conv_abort, 1);
        chk("R7", "result kept on abort", result_q, 12'h222);
        chk("R7", "no upd on abort", result_upd, 0);
        chk("R2", "enables dropped", {adc_en, loop_en, fan_en}, 0);
        conv_done = 1'b1; conv_data = 12'hBAD;
        @(negedge clk);
        conv_done = 1'b0;
        chk("R9", "late done ignored", result_q, 12'h222);
        chk("R9", "late done no upd", result_upd, 0);
        chk("R10", "result kept in standby", result_q, 12'h222);
        cfg_byte = 8'h00;
        wait_start(cyc);
        chk("R3", "restart timing", cyc, BP+1);
    endtask

    task automatic t_simul();
        @(negedge clk);
        conv_done = 1'b1; conv_data = 12'h777; cfg_byte = 8'h40;
        @(negedge clk);
        conv_done = 1'b0;
        chk("R8", "abort on coincident done", conv_abort, 1);
        chk("R8", "coincident data discarded", result_q, 12'h222);
        chk("R8", "no upd on coincident done", result_upd, 0);
        @(negedge clk);
        chk("R8", "still no upd", result_upd, 0);
    endtask

    initial begin
        t_reset();
        t_standby_quiet();
        t_oneshot();
        t_run_period();
        t_abort();
        t_simul();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule